// File: doc/BRIEF.md
# Serial Interface Interrupt Unit

This block gathers single-cycle event pulses from a serial shift engine and its FIFOs into one sticky status register. It then merges that register with a per-source enable mask to drive one registered interrupt line. Six sources are tracked:

- receive-FIFO threshold reached
- transmit FIFO drained to empty
- one word shifted
- whole transmission finished
- receive overflow, which is only possible when sending and receiving at once
- transmit underrun

Software sees two words on a small register bus. The control word holds the enables and a receive-threshold gate. The status word holds the latched events and is cleared by writing ones. Reads are combinational. Writes take effect at the clock edge that samples them.

An enable bit sits at the same position in the control word as its status bit in the status word, so one mask serves both words. A receive-threshold pulse is recorded only while the gate bit is set. Events latch whether or not they are enabled, so software can poll with the interrupt masked.

Top module: `serial_irq_unit`

## Requirements
- R1: After reset the control word, the status word and `irq` all read 0.
- R2: Each event input sets one status bit: receive threshold → bit 0, transmit empty → bit 4, word end → bit 8, transmission end → bit 9, overflow → bit 12, underrun → bit 13. The bit is readable at the first read after the edge that sampled the pulse.
- R3: The control word keeps only bits 0, 4, 8, 9, 12, 13 (enables) and bit 19 (receive-threshold gate). Every other bit reads back 0, so writing all ones reads back 0x00083311.
- R4: Writing 1 to a status bit clears it. Writing 0 leaves it as it was. A status write never sets a bit, and a set bit stays set until cleared.
- R5: When an event and a clear of the same bit land in the same cycle, the bit stays set.
- R6: A receive-threshold pulse leaves status bit 0 unchanged while control bit 19 is 0.
- R7: Status bits latch whether their enable is 0 or 1. With every enable at 0, `irq` stays 0.
- R8: `irq` is the OR over all six sources of (status AND enable), delayed by one register. It rises one cycle after the status bit is set and falls one cycle after the last enabled bit is cleared.
- R9: Reads from an address other than control (0) or status (4) return 0. Writes to such an address change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | AW (3) | Byte address: 0 = control, 4 = status |
| bus_wdata | input | DW (32) | Write data |
| bus_rdata | output | DW (32) | Read data, combinational on `bus_addr` |
| ev_rx_thr | input | 1 | Receive-FIFO threshold pulse |
| ev_tx_empty | input | 1 | Transmit-FIFO empty pulse |
| ev_word_end | input | 1 | Word shifted pulse |
| ev_xfer_end | input | 1 | Transmission finished pulse |
| ev_overflow | input | 1 | Receive overflow pulse |
| ev_underrun | input | 1 | Transmit underrun pulse |
| irq | output | 1 | Registered interrupt request |

## Verification
The assertions assume that each event input is a clean one-cycle pulse, synchronous to `clk`. They also assume that bus write data is stable in the cycle in which `bus_wr` is high.

The bench respects both assumptions. It changes every input only on the falling edge and holds each pulse or write for exactly one cycle. It samples read data and `irq` on the next falling edge, so that each value is read back after the rising edge that captures it.

// File: rtl/serial_irq_unit.sv
module serial_irq_unit #(
  parameter int DW = 32,
  parameter int AW = 3,
  parameter logic [AW-1:0] CTRL_ADDR = 3'd0,
  parameter logic [AW-1:0] STAT_ADDR = 3'd4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          ev_rx_thr,
  input  logic          ev_tx_empty,
  input  logic          ev_word_end,
  input  logic          ev_xfer_end,
  input  logic          ev_overflow,
  input  logic          ev_underrun,
  output logic          irq
);

  localparam int B_RXT  = 0;
  localparam int B_TXE  = 4;
  localparam int B_WEND = 8;
  localparam int B_XEND = 9;
  localparam int B_OVF  = 12;
  localparam int B_UND  = 13;
  localparam int B_GATE = 19;

  localparam logic [DW-1:0] SRC_MASK =
    (DW'(1) << B_RXT) | (DW'(1) << B_TXE) | (DW'(1) << B_WEND) |
    (DW'(1) << B_XEND) | (DW'(1) << B_OVF) | (DW'(1) << B_UND);
  localparam logic [DW-1:0] CTRL_MASK = SRC_MASK | (DW'(1) << B_GATE);

  logic [DW-1:0] ctrl_q, stat_q, set_v, clr_v;
  logic          ctrl_we, stat_we, irq_q;

  assign ctrl_we = bus_wr && (bus_addr == CTRL_ADDR);
  assign stat_we = bus_wr && (bus_addr == STAT_ADDR);

  always_comb begin
    set_v = '0;
    set_v[B_RXT]  = ev_rx_thr && ctrl_q[B_GATE];
    set_v[B_TXE]  = ev_tx_empty;
    set_v[B_WEND] = ev_word_end;
    set_v[B_XEND] = ev_xfer_end;
    set_v[B_OVF]  = ev_overflow;
    set_v[B_UND]  = ev_underrun;
  end

  assign clr_v = stat_we ? (bus_wdata & SRC_MASK) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      stat_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (ctrl_we) ctrl_q <= bus_wdata & CTRL_MASK;
      stat_q <= ((stat_q & ~clr_v) | set_v) & SRC_MASK;
      irq_q  <= |(stat_q & ctrl_q & SRC_MASK);
    end
  end

  assign irq = irq_q;
  assign bus_rdata = (bus_addr == CTRL_ADDR) ? ctrl_q :
                     (bus_addr == STAT_ADDR) ? stat_q : '0;

  // R5
  event_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_underrun |=> stat_q[B_UND]);

  // R6
  rx_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q[B_GATE] && !stat_q[B_RXT]) |=> !stat_q[B_RXT]);

  // R4
  w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_we && bus_wdata[B_OVF] && !ev_overflow) |=> !stat_q[B_OVF]);

  // R4
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q[B_WEND] && !(stat_we && bus_wdata[B_WEND])) |=> stat_q[B_WEND]);

  // R8
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q[B_XEND] && ctrl_q[B_XEND]) |=> irq);

  // R7
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ctrl_q & SRC_MASK) == '0) |=> !irq);

endmodule

// File: tb/serial_irq_unit_test.sv
module serial_irq_unit_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_wr = 1'b0;
  logic [2:0] bus_addr = 3'd0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [5:0] ev = '0;
  logic irq;
  int checks = 0, fails = 0, cycles = 0;

  always #5 clk = ~clk;

  serial_irq_unit uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ev_rx_thr(ev[0]), .ev_tx_empty(ev[1]), .ev_word_end(ev[2]),
    .ev_xfer_end(ev[3]), .ev_overflow(ev[4]), .ev_underrun(ev[5]),
    .irq(irq));

  localparam logic [31:0] BITS [6] = '{32'h1, 32'h10, 32'h100, 32'h200, 32'h1000, 32'h2000};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic w, input logic [2:0] a, input logic [31:0] d, input logic [5:0] e);
    @(negedge clk);
    bus_wr = w; bus_addr = a; bus_wdata = d; ev = e;
    @(negedge clk);
    bus_wr = 1'b0; ev = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(3'd0, d); chk("R1 ctrl", d, 32'h0);
    rd(3'd4, d); chk("R1 status", d, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_ctrl;
    logic [31:0] d;
    cyc(1'b1, 3'd0, 32'hFFFF_FFFF, '0);
    rd(3'd0, d); chk("R3 ctrl mask", d, 32'h0008_3311);
    cyc(1'b1, 3'd2, 32'h0, '0);
    rd(3'd0, d); chk("R9 stray write", d, 32'h0008_3311);
    rd(3'd2, d); chk("R9 stray read", d, 32'h0);
    cyc(1'b1, 3'd0, 32'h0, '0);
    rd(3'd0, d); chk("R3 ctrl clear", d, 32'h0);
  endtask

  task automatic t_map;
    logic [31:0] d;
    cyc(1'b1, 3'd0, 32'h0008_0000, '0);
    for (int i = 0; i < 6; i++) begin
      cyc(1'b0, 3'd0, 32'h0, 6'(1 << i));
      rd(3'd4, d); chk("R2 map", d, BITS[i]);
      chk("R7 masked irq", {31'b0, irq}, 32'h0);
      cyc(1'b1, 3'd4, BITS[i], '0);
      rd(3'd4, d); chk("R4 clear one", d, 32'h0);
    end
    cyc(1'b1, 3'd0, 32'h0, '0);
  endtask

  task automatic t_gate;
    logic [31:0] d;
    cyc(1'b0, 3'd0, 32'h0, 6'b000001);
    rd(3'd4, d); chk("R6 gate closed", d, 32'h0);
  endtask

  task automatic t_w1c;
    logic [31:0] d;
    cyc(1'b0, 3'd0, 32'h0, 6'b111110);
    rd(3'd4, d); chk("R7 latch unmasked", d, 32'h0000_3310);
    cyc(1'b1, 3'd4, 32'h0, '0);
    rd(3'd4, d); chk("R4 write zero", d, 32'h0000_3310);
    cyc(1'b1, 3'd4, 32'h0000_1000, '0);
    rd(3'd4, d); chk("R4 clear overflow", d, 32'h0000_2310);
    cyc(1'b1, 3'd4, 32'hFFFF_FFFF, '0);
    rd(3'd4, d); chk("R4 clear all", d, 32'h0);
  endtask

  task automatic t_race;
    logic [31:0] d;
    cyc(1'b0, 3'd0, 32'h0, 6'b100000);
    cyc(1'b1, 3'd4, 32'h0000_2000, 6'b100000);
    rd(3'd4, d); chk("R5 event wins", d, 32'h0000_2000);
    cyc(1'b1, 3'd4, 32'h0000_2000, '0);
    rd(3'd4, d); chk("R5 cleared after", d, 32'h0);
  endtask

  task automatic t_irq;
    cyc(1'b1, 3'd0, 32'h0000_0010, '0);
    cyc(1'b0, 3'd0, 32'h0, 6'b001000);
    chk("R8 masked source", {31'b0, irq}, 32'h0);
    cyc(1'b1, 3'd0, 32'h0000_0200, '0);
    chk("R8 latency", {31'b0, irq}, 32'h0);
    @(negedge clk);
    chk("R8 rise", {31'b0, irq}, 32'h1);
    cyc(1'b1, 3'd4, 32'h0000_0200, '0);
    chk("R8 hold one cycle", {31'b0, irq}, 32'h1);
    @(negedge clk);
    chk("R8 fall", {31'b0, irq}, 32'h0);
    cyc(1'b1, 3'd0, 32'h0, '0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected <= 5000 cycles", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_reset();
    t_ctrl();
    t_map();
    t_gate();
    t_w1c();
    t_race();
    t_irq();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule